// File: doc/BRIEF.md
# Load-Store Queue with Store Forwarding

This block holds a core's memory instructions in program order between dispatch and commit. Each load or store takes the tail slot when it is dispatched and gets back a tag. Its effective address arrives later through the address port. A store's data arrives, possibly in a different cycle, through the data port.

A load is released only when every older entry in the queue has its address. Once released, the load searches the older stores for one with the same word address and takes the youngest match. If that store already holds its data, the value goes straight to the forwarding output and the cache is not touched. If that store has its address but no data yet, the load waits. If no older store matches, the load sends a read request to the cache.

Stores stay in the queue until the head entry is committed. Only at commit is the store's address and data sent to the cache as a write, and the slot freed. A flush input empties the whole queue in one cycle.

Top module: `ldst_queue`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `alloc_tag` is 0, `head_ready` is 0, and neither `mem_valid` nor `fwd_valid` is asserted.
- R2: Allocations receive tags in program order, starting at 0 and wrapping after DEPTH-1. With DEPTH entries held, `full` is 1 and an allocation request is ignored. Once the head is committed, the freed tag is handed out again.
- R3: A load produces neither a cache request nor a forward while any older entry (load or store) still lacks its address.
- R4: A released load with no older store at the same address raises `mem_valid` with `mem_write`=0, its own address on `mem_addr` and its tag on `mem_tag`.
- R5: A released load whose matching older store holds data raises `fwd_valid` with its tag and the store's data, and makes no cache read for that load.
- R6: When several older stores match, the forwarded value comes from the youngest of them.
- R7: A load whose youngest matching older store has no data yet waits without reading the cache. It forwards in the cycle after the data is written.
- R8: A store reaches the cache only while `commit_valid` commits it at the head. The write shows `mem_write`=1 with the store's address and data, and the slot is freed.
- R9: `commit_valid` is ignored unless the head is complete. A store at the head is complete once it has both address and data. A load at the head is complete once it has been issued or forwarded. An ignored commit leaves the head entry in place.
- R10: At most one cache request is made per cycle. A committing store write takes the port ahead of a load read, and the deferred read is made in the following cycle. Among released loads, the oldest goes first.
- R11: Stores younger than a load never forward to it, even when they hold the same address.
- R12: `flush` empties the queue in the cycle it is sampled: afterwards `full`=0, `alloc_tag`=0 and no request or forward is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discards every entry |
| alloc_valid | input | 1 | Dispatch a memory instruction into the tail slot |
| alloc_is_store | input | 1 | 1 = store, 0 = load for the dispatched entry |
| alloc_tag | output | TW | Tag that the next allocation receives |
| full | output | 1 | All DEPTH slots are occupied |
| addr_valid | input | 1 | Write an effective address |
| addr_tag | input | TW | Entry that receives the address |
| addr_value | input | AW | Word address |
| data_valid | input | 1 | Write store data |
| data_tag | input | TW | Store entry that receives the data |
| data_value | input | DW | Store data |
| commit_valid | input | 1 | Retire the head entry |
| head_ready | output | 1 | Head entry is complete and may commit |
| mem_valid | output | 1 | Cache request this cycle |
| mem_write | output | 1 | 1 = store write, 0 = load read |
| mem_tag | output | TW | Tag of the requesting entry |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data (0 on reads) |
| fwd_valid | output | 1 | A load is satisfied from an older store |
| fwd_tag | output | TW | Tag of the forwarded load |
| fwd_data | output | DW | Forwarded value |

## Verification
Load requests and forwards are driven combinationally from queue state. They therefore appear in the cycle after the clock edge that captured the last address or data they needed, and they vanish after the next edge marks the load done. Store writes appear in the same cycle that `commit_valid` is driven. The bench changes inputs just after a rising edge, lets them settle, and samples outputs before the next edge. Each check falls either in the first cycle after the enabling write, or in the commit cycle itself. Where the requirement calls for it, the bench checks again one cycle later, to show that a waiting or deferred load has not moved.

// File: rtl/ldst_queue.sv
module ldst_queue #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int TW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          alloc_valid,
  input  logic          alloc_is_store,
  output logic [TW-1:0] alloc_tag,
  output logic          full,
  input  logic          addr_valid,
  input  logic [TW-1:0] addr_tag,
  input  logic [AW-1:0] addr_value,
  input  logic          data_valid,
  input  logic [TW-1:0] data_tag,
  input  logic [DW-1:0] data_value,
  input  logic          commit_valid,
  output logic          head_ready,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [TW-1:0] mem_tag,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          fwd_valid,
  output logic [TW-1:0] fwd_tag,
  output logic [DW-1:0] fwd_data
);

  logic [DEPTH-1:0] busy, is_st, a_ok, d_ok, done;
  logic [AW-1:0]    ea [DEPTH];
  logic [DW-1:0]    sd [DEPTH];
  logic [TW-1:0]    head, tail;
  logic [CW-1:0]    occ;

  logic          sel_found, sel_fwd;
  logic [TW-1:0] sel_idx;
  logic [DW-1:0] sel_data;
  logic          commit_fire, st_write, alloc_fire, ld_take;

  function automatic logic [TW-1:0] tag_at(input logic [TW-1:0] h, input int p);
    int s;
    s = int'(h) + p;
    if (s >= DEPTH) s = s - DEPTH;
    return s[TW-1:0];
  endfunction

  function automatic logic [TW-1:0] nxt(input logic [TW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    logic          blk, mf, mh;
    logic [DW-1:0] md;
    logic [TW-1:0] i, j;
    sel_found = 1'b0;
    sel_fwd   = 1'b0;
    sel_idx   = '0;
    sel_data  = '0;
    blk = 1'b0;
    mf  = 1'b0;
    mh  = 1'b0;
    md  = '0;
    i   = '0;
    j   = '0;
    for (int p = 0; p < DEPTH; p++) begin
      i = tag_at(head, p);
      if (p < int'(occ)) begin
        if (!is_st[i] && a_ok[i] && !done[i] && !blk && !sel_found) begin
          mf = 1'b0;
          mh = 1'b0;
          md = '0;
          for (int k = 0; k < DEPTH; k++) begin
            j = tag_at(head, k);
            if (k < p && is_st[j] && ea[j] == ea[i]) begin
              mf = 1'b1;
              mh = d_ok[j];
              md = sd[j];
            end
          end
          if (!mf || mh) begin
            sel_found = 1'b1;
            sel_fwd   = mf;
            sel_idx   = i;
            sel_data  = md;
          end
        end
        if (!a_ok[i]) blk = 1'b1;
      end
    end
  end

  assign full        = (int'(occ) == DEPTH);
  assign alloc_tag   = tail;
  assign head_ready  = (occ != '0) && (is_st[head] ? (a_ok[head] && d_ok[head]) : done[head]);
  assign commit_fire = commit_valid && head_ready && !flush;
  assign st_write    = commit_fire && is_st[head];
  assign alloc_fire  = alloc_valid && !full && !flush;

  assign mem_valid = st_write || (sel_found && !sel_fwd && !flush);
  assign mem_write = st_write;
  assign mem_tag   = st_write ? head : sel_idx;
  assign mem_addr  = st_write ? ea[head] : ea[sel_idx];
  assign mem_wdata = st_write ? sd[head] : '0;

  assign fwd_valid = sel_found && sel_fwd && !flush;
  assign fwd_tag   = sel_idx;
  assign fwd_data  = sel_data;

  assign ld_take = fwd_valid || (mem_valid && !mem_write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      is_st <= '0;
      a_ok <= '0;
      d_ok <= '0;
      done <= '0;
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else if (flush) begin
      busy <= '0;
      a_ok <= '0;
      d_ok <= '0;
      done <= '0;
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (alloc_fire) begin
        busy[tail]  <= 1'b1;
        is_st[tail] <= alloc_is_store;
        a_ok[tail]  <= 1'b0;
        d_ok[tail]  <= 1'b0;
        done[tail]  <= 1'b0;
        tail <= nxt(tail);
      end
      if (addr_valid && int'(addr_tag) < DEPTH && busy[addr_tag])
        a_ok[addr_tag] <= 1'b1;
      if (data_valid && int'(data_tag) < DEPTH && busy[data_tag] && is_st[data_tag])
        d_ok[data_tag] <= 1'b1;
      if (ld_take)
        done[sel_idx] <= 1'b1;
      if (commit_fire) begin
        busy[head] <= 1'b0;
        head <= nxt(head);
      end
      occ <= occ + CW'(alloc_fire) - CW'(commit_fire);
    end
  end

  always_ff @(posedge clk) begin
    if (addr_valid && int'(addr_tag) < DEPTH && busy[addr_tag] && !flush)
      ea[addr_tag] <= addr_value;
    if (data_valid && int'(data_tag) < DEPTH && busy[data_tag] && is_st[data_tag] && !flush)
      sd[data_tag] <= data_value;
  end

endmodule

// File: rtl/ldst_queue_chk.sv
module ldst_queue_chk #(
  parameter int TW = 3,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          alloc_valid,
  input logic [TW-1:0] alloc_tag,
  input logic          full,
  input logic          commit_valid,
  input logic          mem_valid,
  input logic          mem_write,
  input logic [TW-1:0] mem_tag,
  input logic          fwd_valid,
  input logic [TW-1:0] fwd_tag,
  input logic [CW-1:0] occ
);

  a_r8_write_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> commit_valid);

  a_r5_fwd_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && mem_valid && !mem_write |-> fwd_tag != mem_tag);

  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    full && alloc_valid && !commit_valid && !flush |=> full && $stable(alloc_tag));

  a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0 && !full && alloc_tag == '0);

  a_r1_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    occ == '0 |-> !mem_valid && !fwd_valid);

endmodule

bind ldst_queue ldst_queue_chk #(.TW(TW), .CW(CW)) u_chk (.*);

// File: tb/test_ldst_queue.sv
module test_ldst_queue;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush, alloc_valid, alloc_is_store, addr_valid, data_valid, commit_valid;
  logic [TW-1:0] addr_tag, data_tag;
  logic [31:0] addr_value, data_value;
  logic [TW-1:0] alloc_tag, mem_tag, fwd_tag;
  logic full, head_ready, mem_valid, mem_write, fwd_valid;
  logic [31:0] mem_addr, mem_wdata, fwd_data;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ldst_queue i_ldst_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
    .alloc_tag(alloc_tag), .full(full),
    .addr_valid(addr_valid), .addr_tag(addr_tag), .addr_value(addr_value),
    .data_valid(data_valid), .data_tag(data_tag), .data_value(data_value),
    .commit_valid(commit_valid), .head_ready(head_ready),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_tag(mem_tag),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fwd_valid(fwd_valid), .fwd_tag(fwd_tag), .fwd_data(fwd_data)
  );

  // store address, store data, load address
  localparam logic [95:0] VEC [0:5] = '{
    {32'h0000_0100, 32'h0000_AAAA, 32'h0000_0100},
    {32'h0000_0100, 32'h0000_BBBB, 32'h0000_0104},
    {32'h0000_0000, 32'h1234_5678, 32'h0000_0000},
    {32'hFFFF_FFFC, 32'hDEAD_BEEF, 32'h7FFF_FFFC},
    {32'h0000_0200, 32'h0000_0001, 32'h0000_0201},
    {32'h8000_0040, 32'hCAFE_F00D, 32'h8000_0040}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; alloc_valid = 0; alloc_is_store = 0;
    addr_valid = 0; addr_tag = '0; addr_value = '0;
    data_valid = 0; data_tag = '0; data_value = '0;
    commit_valid = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle();
    #1;
  endtask

  task automatic do_flush();
    flush = 1; tick();
  endtask

  task automatic alloc(input logic st);
    alloc_valid = 1; alloc_is_store = st; tick();
  endtask

  task automatic put_addr(input logic [TW-1:0] t, input logic [31:0] a);
    addr_valid = 1; addr_tag = t; addr_value = a;
  endtask

  task automatic put_data(input logic [TW-1:0] t, input logic [31:0] d);
    data_valid = 1; data_tag = t; data_value = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1
    chk("R1", "full", full, 0);
    chk("R1", "alloc_tag", alloc_tag, 0);
    chk("R1", "head_ready", head_ready, 0);
    chk("R1", "mem_valid", mem_valid, 0);
    chk("R1", "fwd_valid", fwd_valid, 0);

    // table: R4 / R5 / R8
    for (int v = 0; v < 6; v++) begin
      logic [31:0] sa, sd, la;
      sa = VEC[v][95:64]; sd = VEC[v][63:32]; la = VEC[v][31:0];
      do_flush();
      alloc(1);
      alloc(0);
      put_addr(0, sa); put_data(0, sd); tick();
      put_addr(1, la); tick();
      if (sa == la) begin
        chk("R5", "fwd_valid", fwd_valid, 1);
        chk("R5", "fwd_tag", fwd_tag, 1);
        chk("R5", "fwd_data", fwd_data, sd);
        chk("R5", "mem_valid", mem_valid, 0);
      end else begin
        chk("R4", "mem_valid", mem_valid, 1);
        chk("R4", "mem_write", mem_write, 0);
        chk("R4", "mem_addr", mem_addr, la);
        chk("R4", "mem_tag", mem_tag, 1);
        chk("R4", "fwd_valid", fwd_valid, 0);
      end
      tick();
      chk("R8", "no write before commit", mem_valid, 0);
      commit_valid = 1; #1;
      chk("R8", "mem_write", mem_valid & mem_write, 1);
      chk("R8", "mem_addr", mem_addr, sa);
      chk("R8", "mem_wdata", mem_wdata, sd);
      tick();
      commit_valid = 1; tick();
    end

    // R3 and R9
    do_flush();
    alloc(0); alloc(1); alloc(0);
    put_addr(2, 32'h40); tick();
    chk("R3", "blocked mem_valid", mem_valid, 0);
    chk("R3", "blocked fwd_valid", fwd_valid, 0);
    put_addr(0, 32'h10); tick();
    chk("R3", "oldest load read", mem_valid, 1);
    chk("R3", "oldest load tag", mem_tag, 0);
    tick();
    chk("R3", "still blocked by store", mem_valid, 0);
    put_addr(1, 32'h80); tick();
    chk("R4", "released read", mem_valid & ~mem_write, 1);
    chk("R4", "released tag", mem_tag, 2);
    chk("R4", "released addr", mem_addr, 32'h40);
    tick();
    commit_valid = 1; #1;
    chk("R9", "load head ready", head_ready, 1);
    tick();
    commit_valid = 1; #1;
    chk("R9", "store head not ready", head_ready, 0);
    chk("R9", "ignored commit no write", mem_valid, 0);
    tick();
    put_data(1, 32'h77); tick();
    commit_valid = 1; #1;
    chk("R9", "retained store written", mem_valid & mem_write, 1);
    chk("R9", "retained addr", mem_addr, 32'h80);
    chk("R9", "retained data", mem_wdata, 32'h77);
    tick();

    // R6 and R11
    do_flush();
    alloc(1); alloc(1); alloc(0); alloc(1);
    put_addr(0, 32'h20); put_data(0, 32'h111); tick();
    put_addr(1, 32'h20); put_data(1, 32'h222); tick();
    put_addr(3, 32'h20); put_data(3, 32'h333); tick();
    put_addr(2, 32'h20); tick();
    chk("R6", "fwd_valid", fwd_valid, 1);
    chk("R6", "youngest older data", fwd_data, 32'h222);
    chk("R11", "younger store ignored", fwd_data != 32'h333, 1);
    chk("R6", "fwd_tag", fwd_tag, 2);

    // R7
    do_flush();
    alloc(1); alloc(0);
    put_addr(0, 32'h30); tick();
    put_addr(1, 32'h30); tick();
    chk("R7", "wait fwd", fwd_valid, 0);
    chk("R7", "wait mem", mem_valid, 0);
    tick();
    chk("R7", "still wait mem", mem_valid, 0);
    put_data(0, 32'h5A); tick();
    chk("R7", "fwd after data", fwd_valid, 1);
    chk("R7", "fwd data", fwd_data, 32'h5A);
    chk("R7", "fwd tag", fwd_tag, 1);

    // R10 write priority
    do_flush();
    alloc(1); alloc(0);
    put_addr(0, 32'h50); put_data(0, 32'h1); tick();
    put_addr(1, 32'h60); tick();
    commit_valid = 1; #1;
    chk("R10", "store wins", mem_write, 1);
    chk("R10", "store addr", mem_addr, 32'h50);
    tick();
    chk("R10", "deferred read", mem_valid & ~mem_write, 1);
    chk("R10", "deferred addr", mem_addr, 32'h60);

    // R10 oldest load first
    do_flush();
    alloc(0); alloc(0);
    put_addr(1, 32'h8); tick();
    put_addr(0, 32'h4); tick();
    chk("R10", "oldest first tag", mem_tag, 0);
    tick();
    chk("R10", "second load tag", mem_tag, 1);
    chk("R10", "second load addr", mem_addr, 32'h8);

    // R2
    do_flush();
    for (int i = 0; i < 8; i++) begin
      chk("R2", "tag order", alloc_tag, i);
      chk("R2", "not full", full, 0);
      alloc(0);
    end
    chk("R2", "full", full, 1);
    chk("R2", "tag wrapped", alloc_tag, 0);
    alloc(0);
    chk("R2", "still full", full, 1);
    put_addr(0, 32'h4); tick();
    tick();
    commit_valid = 1; tick();
    chk("R2", "slot freed", full, 0);
    chk("R2", "reuse tag", alloc_tag, 0);
    alloc(0);
    chk("R2", "full again", full, 1);

    // R12
    do_flush();
    chk("R12", "full", full, 0);
    chk("R12", "alloc_tag", alloc_tag, 0);
    chk("R12", "mem_valid", mem_valid, 0);
    chk("R12", "fwd_valid", fwd_valid, 0);
    chk("R12", "head_ready", head_ready, 0);

    summary();
    $finish;
  end
endmodule